// File: doc/BRIEF.md
# Grouped GPIO Interrupt Status Aggregator

This block gathers single-cycle event pulses from a set of pads and folds them into one shared interrupt line. Pads are split into groups of a parameterised size, at most 32. Each group has a status word, which latches events, and an enable word, which selects the pads allowed to raise the interrupt. Group g holds pad indices g*GRP_SIZE up to g*GRP_SIZE+GRP_SIZE-1. Bit b of that group's words belongs to pad g*GRP_SIZE+b. When the pad count is not a multiple of the group size, the last group is only partly populated.

The host reads and writes the two banks through a simple word-addressed register port. Status bits clear when a 1 is written to them. Each pad also has a host-ownership input. A pad whose ownership input is low cannot set its status bit, so pads that another agent controls never disturb the host's interrupt.

To enable a pad without acting on an old event, the host first clears the pad's status bit and then sets its enable bit.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset, every status word and every enable word reads 0 and irq_out is 0.
- R2: A pulse on pad_evt[p] while pad_host_own[p] is 1 sets bit (p mod GRP_SIZE) of the status word at address STS_BASE + 4*(p div GRP_SIZE). The bit reads back as set in the cycle after the pulse.
- R3: A write to a status word clears each bit whose write-data bit is 1 and leaves alone each bit whose write-data bit is 0. Writing 0xFFFF clears the whole group when GRP_SIZE is 16.
- R4: An event and a clearing write that reach the same status bit in the same cycle leave the bit set.
- R5: A write to address EN_BASE + 4*g stores the low GRP_SIZE data bits as group g's enable word, and the word reads back at that address.
- R6: irq_out is registered. It goes to 1 one cycle after some bit is set in both a status word and the matching enable word. It goes back to 0 one cycle after no such bit remains.
- R7: A status bit whose enable bit is 0 never drives irq_out. Such a bit still reads as set until it is cleared.
- R8: An event on a pad whose pad_host_own bit is 0 leaves that pad's status bit at 0.
- R9: In the last group, the bit positions beyond NUM_PADS always read 0 in both banks and never count as pending. This holds even after a write of all ones.
- R10: A write to an address that is not a multiple of 4, or that falls outside both banks, changes no state. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_evt | input | NUM_PADS | One-cycle event pulse per pad |
| pad_host_own | input | NUM_PADS | 1 when the host owns the pad; 0 blocks status updates |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data; only the low GRP_SIZE bits are used |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Registered OR of all pending (status AND enable) bits |

## Verification
The bound checker watches four things on every cycle:
- irq_out follows the pending set with exactly one cycle of delay.
- A status bit rises only after an event on an owned pad.
- An owned event is never lost, even when a clearing write hits the same cycle.
- The unpopulated tail bits stay at zero.

Only the directed scenarios can show the rest: the pad-to-group-and-bit address mapping, the write-one-to-clear masking, the enable read-back, the return of irq_out to 0 after a clear, and that misaligned or out-of-range accesses neither change state nor return data.

// File: rtl/gpio_irq_agg_pkg.sv
package gpio_irq_agg_pkg;

   typedef enum logic [1:0] {
      BANK_NONE = 2'd0,
      BANK_STS  = 2'd1,
      BANK_EN   = 2'd2
   } bank_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/gpio_irq_agg_decode.sv
module gpio_irq_agg_decode
   import gpio_irq_agg_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int NGRP     = 3,
   parameter int STS_BASE = 'h100,
   parameter int EN_BASE  = 'h180,
   parameter int GIDX_W   = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output bank_e             bank,
   output logic [GIDX_W-1:0] grp
);

   localparam logic [ADDR_W-1:0] STS_LO = ADDR_W'(STS_BASE);
   localparam logic [ADDR_W-1:0] EN_LO  = ADDR_W'(EN_BASE);
   localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(4 * NGRP);

   logic [ADDR_W-1:0] sts_off;
   logic [ADDR_W-1:0] en_off;
   logic              aligned;
   logic              unused_off;

   assign sts_off    = addr - STS_LO;
   assign en_off     = addr - EN_LO;
   assign aligned    = (addr[1:0] == 2'b00);
   assign unused_off = ^{sts_off, en_off};

   always_comb begin
      bank = BANK_NONE;
      grp  = '0;
      if (aligned && (addr >= STS_LO) && (sts_off < SPAN)) begin
         bank = BANK_STS;
         grp  = sts_off[GIDX_W+1:2];
      end else if (aligned && (addr >= EN_LO) && (en_off < SPAN)) begin
         bank = BANK_EN;
         grp  = en_off[GIDX_W+1:2];
      end
   end

endmodule

// File: rtl/gpio_irq_agg_group.sv
module gpio_irq_agg_group #(
   parameter int GRP_SIZE = 16,
   parameter int POP      = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [GRP_SIZE-1:0] evt,
   input  logic [GRP_SIZE-1:0] own,
   input  logic                clr_wr,
   input  logic                en_wr,
   input  logic [GRP_SIZE-1:0] wdata,
   output logic [GRP_SIZE-1:0] sts_q,
   output logic [GRP_SIZE-1:0] en_q
);

   logic [GRP_SIZE-1:0] vmask;
   logic [GRP_SIZE-1:0] clr_mask;
   logic [GRP_SIZE-1:0] set_mask;

   for (genvar b = 0; b < GRP_SIZE; b++) begin : g_mask
      if (b < POP) begin : g_pop
         assign vmask[b] = 1'b1;
      end else begin : g_empty
         assign vmask[b] = 1'b0;
      end
   end

   assign clr_mask = clr_wr ? wdata : '0;
   assign set_mask = evt & own;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q <= '0;
         en_q  <= '0;
      end else begin
         sts_q <= ((sts_q & ~clr_mask) | set_mask) & vmask;
         if (en_wr) begin
            en_q <= wdata & vmask;
         end
      end
   end

endmodule

// File: rtl/gpio_irq_agg_combine.sv
module gpio_irq_agg_combine #(
   parameter int WIDTH = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sts,
   input  logic [WIDTH-1:0] en,
   output logic             irq_q
);

   logic any_pending;

   assign any_pending = |(sts & en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= any_pending;
      end
   end

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
   import gpio_irq_agg_pkg::*;
#(
   parameter int NUM_PADS = 40,
   parameter int GRP_SIZE = 16,
   parameter int ADDR_W   = 12,
   parameter int STS_BASE = 'h100,
   parameter int EN_BASE  = 'h180
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PADS-1:0] pad_evt,
   input  logic [NUM_PADS-1:0] pad_host_own,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic                irq_out
);

   localparam int NGRP      = ceil_div(NUM_PADS, GRP_SIZE);
   localparam int NUM_SLOTS = NGRP * GRP_SIZE;
   localparam int GIDX_W    = idx_width(NGRP);

   if (GRP_SIZE < 1 || GRP_SIZE > 32) begin : g_bad_grp
      $error("gpio_irq_agg: GRP_SIZE must lie in 1..32");
   end
   if (NUM_PADS < 1) begin : g_bad_pads
      $error("gpio_irq_agg: NUM_PADS must be at least 1");
   end
   if (ADDR_W < GIDX_W + 2) begin : g_bad_addr
      $error("gpio_irq_agg: ADDR_W too narrow for the group count");
   end
   if ((STS_BASE % 4) != 0 || (EN_BASE % 4) != 0) begin : g_bad_align
      $error("gpio_irq_agg: bank bases must be word aligned");
   end
   if (!((EN_BASE >= STS_BASE + 4 * NGRP) || (STS_BASE >= EN_BASE + 4 * NGRP))) begin : g_bad_overlap
      $error("gpio_irq_agg: status and enable banks overlap");
   end

   logic [NUM_SLOTS-1:0] evt_ext;
   logic [NUM_SLOTS-1:0] own_ext;
   logic [NUM_SLOTS-1:0] sts_flat;
   logic [NUM_SLOTS-1:0] en_flat;
   logic [GRP_SIZE-1:0]  sts_arr [NGRP];
   logic [GRP_SIZE-1:0]  en_arr  [NGRP];
   bank_e                dec_bank;
   logic [GIDX_W-1:0]    dec_grp;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      if (s < NUM_PADS) begin : g_real
         assign evt_ext[s] = pad_evt[s];
         assign own_ext[s] = pad_host_own[s];
      end else begin : g_pad
         assign evt_ext[s] = 1'b0;
         assign own_ext[s] = 1'b0;
      end
   end

   if (GRP_SIZE < 32) begin : g_wdata_hi
      logic unused_wdata;
      assign unused_wdata = ^reg_wdata[31:GRP_SIZE];
   end

   gpio_irq_agg_decode #(
      .ADDR_W   (ADDR_W),
      .NGRP     (NGRP),
      .STS_BASE (STS_BASE),
      .EN_BASE  (EN_BASE),
      .GIDX_W   (GIDX_W)
   ) i_decode (
      .addr (reg_addr),
      .bank (dec_bank),
      .grp  (dec_grp)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int REMAIN = NUM_PADS - g * GRP_SIZE;
      localparam int POP    = (REMAIN >= GRP_SIZE) ? GRP_SIZE : REMAIN;

      logic sel;
      assign sel = (dec_grp == GIDX_W'(g));

      gpio_irq_agg_group #(
         .GRP_SIZE (GRP_SIZE),
         .POP      (POP)
      ) i_group (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt    (evt_ext[g*GRP_SIZE +: GRP_SIZE]),
         .own    (own_ext[g*GRP_SIZE +: GRP_SIZE]),
         .clr_wr (reg_wr && (dec_bank == BANK_STS) && sel),
         .en_wr  (reg_wr && (dec_bank == BANK_EN) && sel),
         .wdata  (reg_wdata[GRP_SIZE-1:0]),
         .sts_q  (sts_arr[g]),
         .en_q   (en_arr[g])
      );

      assign sts_flat[g*GRP_SIZE +: GRP_SIZE] = sts_arr[g];
      assign en_flat[g*GRP_SIZE +: GRP_SIZE]  = en_arr[g];
   end

   always_comb begin
      reg_rdata = '0;
      case (dec_bank)
         BANK_STS: reg_rdata = 32'(sts_arr[dec_grp]);
         BANK_EN:  reg_rdata = 32'(en_arr[dec_grp]);
         default:  reg_rdata = '0;
      endcase
   end

   gpio_irq_agg_combine #(
      .WIDTH (NUM_SLOTS)
   ) i_combine (
      .clk   (clk),
      .rst_n (rst_n),
      .sts   (sts_flat),
      .en    (en_flat),
      .irq_q (irq_out)
   );

endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk #(
   parameter int NUM_PADS  = 40,
   parameter int NUM_SLOTS = 48
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_PADS-1:0]  pad_evt,
   input logic [NUM_PADS-1:0]  pad_host_own,
   input logic [NUM_SLOTS-1:0] sts_flat,
   input logic [NUM_SLOTS-1:0] en_flat,
   input logic                 irq_out
);

   assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sts_flat & en_flat)) |=> irq_out);

   assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(sts_flat & en_flat)) |=> !irq_out);

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      // R2 and R8: a status bit only rises after an owned event
      assert_owned_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sts_flat[p]) |-> $past(pad_evt[p] && pad_host_own[p]));

      assert_evt_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (pad_evt[p] && pad_host_own[p]) |=> sts_flat[p]);
   end

   for (genvar s = NUM_PADS; s < NUM_SLOTS; s++) begin : g_tail
      assert_tail_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !sts_flat[s] && !en_flat[s]);
   end

endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(
   .NUM_PADS  (NUM_PADS),
   .NUM_SLOTS (NUM_SLOTS)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pad_evt      (pad_evt),
   .pad_host_own (pad_host_own),
   .sts_flat     (sts_flat),
   .en_flat      (en_flat),
   .irq_out      (irq_out)
);

// File: tb/test_gpio_irq_agg.sv
module test_gpio_irq_agg;

   localparam int NUM_PADS = 40;
   localparam int GRP_SIZE = 16;
   localparam int ADDR_W   = 12;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NUM_PADS-1:0] pad_evt = '0;
   logic [NUM_PADS-1:0] pad_host_own = '1;
   logic [ADDR_W-1:0]   reg_addr = '0;
   logic                reg_wr = 1'b0;
   logic [31:0]         reg_wdata = '0;
   logic [31:0]         reg_rdata;
   logic                irq_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   gpio_irq_agg #(
      .NUM_PADS (NUM_PADS),
      .GRP_SIZE (GRP_SIZE),
      .ADDR_W   (ADDR_W),
      .STS_BASE ('h100),
      .EN_BASE  ('h180)
   ) i_gpio_irq_agg (
      .clk          (clk),
      .rst_n        (rst_n),
      .pad_evt      (pad_evt),
      .pad_host_own (pad_host_own),
      .reg_addr     (reg_addr),
      .reg_wr       (reg_wr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .irq_out      (irq_out)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input int p);
      @(negedge clk);
      pad_evt[p] = 1'b1;
      @(negedge clk);
      pad_evt[p] = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int g = 0; g < 3; g++) begin
         rd(ADDR_W'('h100 + 4 * g), d);
         check("R1 status after reset", d, 0);
         rd(ADDR_W'('h180 + 4 * g), d);
         check("R1 enable after reset", d, 0);
      end
      check("R1 irq after reset", 32'(irq_out), 0);
   endtask

   task automatic t_map();
      logic [31:0] d;
      pulse(21);
      rd('h104, d);
      check("R2 pad 21 -> group 1 bit 5", d, 32'h20);
      pulse(3);
      rd('h100, d);
      check("R2 pad 3 -> group 0 bit 3", d, 32'h8);
      @(negedge clk);
      check("R7 no irq while enables are off", 32'(irq_out), 0);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      wr('h104, 32'h0);
      rd('h104, d);
      check("R3 writing zero keeps status", d, 32'h20);
      wr('h104, 32'h10);
      rd('h104, d);
      check("R3 clearing another bit keeps status", d, 32'h20);
      wr('h104, 32'h20);
      rd('h104, d);
      check("R3 writing one clears status", d, 0);
      wr('h100, 32'hFFFF);
      rd('h100, d);
      check("R3 0xFFFF clears whole group", d, 0);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wr('h184, 32'h20);
      rd('h184, d);
      check("R5 enable read back", d, 32'h20);
      check("R6 no irq before event", 32'(irq_out), 0);
      pulse(21);
      check("R6 irq still low one cycle after event", 32'(irq_out), 0);
      @(negedge clk);
      check("R6 irq rises after pending", 32'(irq_out), 1);
      wr('h104, 32'h20);
      check("R6 irq still high at clear edge", 32'(irq_out), 1);
      @(negedge clk);
      check("R6 irq falls after clear", 32'(irq_out), 0);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      @(negedge clk);
      pad_evt[21] = 1'b1;
      reg_addr    = 'h104;
      reg_wdata   = 32'h20;
      reg_wr      = 1'b1;
      @(negedge clk);
      pad_evt[21] = 1'b0;
      reg_wr      = 1'b0;
      rd('h104, d);
      check("R4 event beats same-cycle clear", d, 32'h20);
      wr('h104, 32'h20);
      wr('h184, 32'h0);
      @(negedge clk);
      check("R6 irq low after cleanup", 32'(irq_out), 0);
   endtask

   task automatic t_unowned();
      logic [31:0] d;
      pad_host_own[9] = 1'b0;
      pulse(9);
      rd('h100, d);
      check("R8 unowned pad does not set status", d, 0);
      pad_host_own[9] = 1'b1;
      pulse(9);
      rd('h100, d);
      check("R8 owned pad sets status again", d, 32'h200);
      wr('h100, 32'h200);
   endtask

   task automatic t_tail();
      logic [31:0] d;
      wr('h188, 32'hFFFF_FFFF);
      rd('h188, d);
      check("R9 tail enable bits stay zero", d, 32'hFF);
      pulse(39);
      rd('h108, d);
      check("R9 last populated pad sets bit 7", d, 32'h80);
      @(negedge clk);
      check("R6 irq from last group", 32'(irq_out), 1);
      wr('h108, 32'hFFFF_FFFF);
      rd('h108, d);
      check("R9 last group clears, tail zero", d, 0);
      wr('h188, 32'h0);
   endtask

   task automatic t_badaddr();
      logic [31:0] d;
      wr('h182, 32'hFF);
      rd('h180, d);
      check("R10 misaligned enable write ignored", d, 0);
      wr('h18C, 32'hFF);
      rd('h18C, d);
      check("R10 out-of-range read is zero", d, 0);
      rd('h180, d);
      check("R10 out-of-range write left group 0", d, 0);
      pulse(20);
      wr('h105, 32'hFFFF);
      rd('h104, d);
      check("R10 misaligned status write ignored", d, 32'h10);
      rd('h105, d);
      check("R10 misaligned read is zero", d, 0);
      wr('h104, 32'h10);
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map();
      t_w1c();
      t_irq();
      t_collide();
      t_unowned();
      t_tail();
      t_badaddr();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule